// File: doc/BRIEF.md
# Operand Address Unit

This unit turns the 3-bit mode field and the 3-bit register field of an operand specifier into the location of that operand. It runs as a small sequencer. It reads base and index registers through a combinational register read port. It pulls 16-bit extension words from an instruction stream port with a request/acknowledge handshake. When the location is known it reports one of four results: a register index, a memory address, an immediate value, or an illegal-specifier mark.

For the post-increment and pre-decrement modes the unit also emits the new value of the address register, with a step that depends on the operand size. It does not update the register file itself. It does not access data memory and it does not decode instructions.

A controller pulses `start` with the fields and the current program counter, then waits for the one-cycle `done` pulse. The result stays on the outputs until the next accepted start. A read-modify-write can therefore use the same location twice without fetching the extension words again.

Top module: `opaddr_unit`

## Requirements
- R1: After reset `done`, `wb_en` and `ext_req` are all low.
- R2: Mode 0 gives location kind 0 (register) with index 0–7 equal to the register field. Mode 1 gives index 8–15, the register field plus 8. Neither mode fetches a word.
- R3: Mode 2 gives kind 1 (memory) with the address equal to the selected address register. No register write-back is produced.
- R4: Mode 3 gives the address register value as the address. It also produces a write-back of that value plus 4 for size 2 or 3 (long), or plus 2 for size 0 (byte) and size 1 (word). `wb_idx` names the address register, 8 plus the register field.
- R5: Mode 4 subtracts the step first (4 for long, 2 otherwise). It uses the decremented value both as the address and as the write-back value.
- R6: Mode 5 fetches one word and adds it, sign-extended, to the address register. `pc_next` is the start program counter plus 2.
- R7: Mode 6 fetches an index word. Bits 15–12 pick the index register, where 0–7 are data and 8–15 are address registers. Bit 11 set adds the full 32-bit index. Bit 11 clear adds the sign-extended low 16 bits. Bits 7–0 are a signed 8-bit offset, and all three terms are summed.
- R8: Mode 7 with register 0 fetches one word and sign-extends it into the address. Register 1 fetches two words, high half first, and advances `pc_next` by 4.
- R9: Mode 7 with register 2 (displacement) or 3 (index) uses the start program counter, before any extension fetch, as the base.
- R10: Mode 7 with register 4 gives kind 2 (immediate). Byte size keeps the low 8 bits of one word. Word size keeps one full word. Long size joins two words, high half first.
- R11: Mode 7 with register 5, 6 or 7 gives kind 3 (illegal), with no fetch, no write-back, and `pc_next` equal to the start program counter.
- R12: While `ext_ack` is low, `ext_req` and `ext_addr` hold. Each accepted word moves `ext_addr` up by 2, and wait states do not change the result.
- R13: `done` lasts one cycle. Results hold until the next start, and a start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calculation (accepted only when idle) |
| mode_i | input | 3 | Mode field |
| regf_i | input | 3 | Register field |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2/3 long |
| pc_i | input | 32 | Address of the first extension word |
| ext_req | output | 1 | Extension word request |
| ext_addr | output | 32 | Address of requested extension word |
| ext_ack | input | 1 | Word accepted this cycle |
| ext_data | input | 16 | Extension word |
| rf_idx | output | 4 | Register read index |
| rf_data | input | 32 | Register read data |
| done | output | 1 | Result valid pulse |
| loc | output | 2 | Kind: 0 register, 1 memory, 2 immediate, 3 illegal |
| reg_idx | output | 4 | Register index for kind 0 |
| addr | output | 32 | Memory address for kind 1 |
| imm | output | 32 | Immediate value for kind 2 |
| wb_en | output | 1 | Address register write-back, with done |
| wb_idx | output | 4 | Register to write back |
| wb_val | output | 32 | Write-back value |
| pc_next | output | 32 | Program counter after the extension words |

## Verification
Each addressing mode is driven with register and extension values whose sign bits are set. This separates sign extension from zero extension and shows any truncation of the index.

The index word is tried three ways: with a data register in half-width form, with the same register in full-width form, and with an address register. These tell apart the width bit, the register-select bits and the sign of the 8-bit offset.

Byte, word and long sizes run through the step and immediate paths. A case with alternating wait states, plus a start pulse issued mid-calculation, separates correct handshaking from fetch counting and from result corruption.

// File: rtl/opa_pkg.sv
// Shared types for the operand address unit.
// Assumes a 16-entry register file: indices 0-7 data, 8-15 address.
package opa_pkg;
    localparam int REG_IDX_W = 4;

    typedef enum logic [3:0] {
        AM_DREG, AM_AREG, AM_IND, AM_POST, AM_PRE, AM_DISP, AM_INDEX,
        AM_ABSW, AM_ABSL, AM_PCDISP, AM_PCINDEX, AM_IMM, AM_BAD
    } amode_t;

    typedef enum logic [1:0] {LOC_REG, LOC_MEM, LOC_IMM, LOC_BAD} loc_t;

    typedef enum logic [2:0] {ST_IDLE, ST_BASE, ST_EXT1, ST_EXT2, ST_INDEX} state_t;
endpackage

// File: rtl/opa_mode_map.sv
// Maps the mode and register fields onto one of twelve addressing modes
// (mode 7 expands by its register field) and derives fetch needs.
// Assumes size codes 2 and 3 both mean long.
module opa_mode_map
    import opa_pkg::*;
(
    input  logic [2:0]           mode,
    input  logic [2:0]           regf,
    input  logic [1:0]           size,
    output amode_t               am,
    output logic [REG_IDX_W-1:0] base_idx,
    output logic                 two_words,
    output logic                 is_index,
    output logic                 pc_based
);
    // Expand the extended group and classify the result.
    always_comb begin
        if (mode != 3'd7) begin
            am = amode_t'({1'b0, mode});
        end else begin
            case (regf)
                3'd0:    am = AM_ABSW;
                3'd1:    am = AM_ABSL;
                3'd2:    am = AM_PCDISP;
                3'd3:    am = AM_PCINDEX;
                3'd4:    am = AM_IMM;
                default: am = AM_BAD;
            endcase
        end
        base_idx  = {(mode != 3'd0), regf};
        two_words = (am == AM_ABSL) || ((am == AM_IMM) && size[1]);
        is_index  = (am == AM_INDEX) || (am == AM_PCINDEX);
        pc_based  = (am == AM_PCDISP) || (am == AM_PCINDEX);
    end
endmodule

// File: rtl/opa_size_step.sv
// Produces the incremented and decremented register values for the
// auto-update modes; the step is 4 for long operands, 2 otherwise.
module opa_size_step #(
    parameter int AW = 32
) (
    input  logic [1:0]    size,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] inc_val,
    output logic [AW-1:0] dec_val
);
    logic [AW-1:0] step;

    // Size-dependent step and both adjusted values.
    always_comb begin
        step    = size[1] ? AW'(4) : AW'(2);
        inc_val = base + step;
        dec_val = base - step;
    end
endmodule

// File: rtl/opa_index_add.sv
// Sums base, index register and 8-bit offset from an index extension word.
// Assumes AW > EW and that the index register value arrives on idx_val.
module opa_index_add #(
    parameter int AW = 32,
    parameter int EW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [EW-1:0] ext_word,
    input  logic [AW-1:0] idx_val,
    output logic [AW-1:0] ea
);
    logic [AW-1:0] idx_ext;
    logic [AW-1:0] off_ext;

    // Select index width by bit 11 and sign-extend the low-byte offset.
    always_comb begin
        idx_ext = ext_word[11] ? idx_val : {{(AW-EW){idx_val[EW-1]}}, idx_val[EW-1:0]};
        off_ext = {{(AW-8){ext_word[7]}}, ext_word[7:0]};
        ea      = base + idx_ext + off_ext;
    end
endmodule

// File: rtl/opaddr_unit.sv
// Operand address unit: sequences base register read, up to two
// extension word fetches and an index register read, then presents a
// held result with a one-cycle done pulse.
// Assumes a combinational register read port and a request/ack word port.
module opaddr_unit
    import opa_pkg::*;
#(
    parameter int AW = 32,
    parameter int EW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           mode_i,
    input  logic [2:0]           regf_i,
    input  logic [1:0]           size_i,
    input  logic [AW-1:0]        pc_i,
    output logic                 ext_req,
    output logic [AW-1:0]        ext_addr,
    input  logic                 ext_ack,
    input  logic [EW-1:0]        ext_data,
    output logic [REG_IDX_W-1:0] rf_idx,
    input  logic [AW-1:0]        rf_data,
    output logic                 done,
    output logic [1:0]           loc,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [AW-1:0]        addr,
    output logic [AW-1:0]        imm,
    output logic                 wb_en,
    output logic [REG_IDX_W-1:0] wb_idx,
    output logic [AW-1:0]        wb_val,
    output logic [AW-1:0]        pc_next
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(EW / 8);

    state_t               st, nxt;
    logic [2:0]           mode_q, regf_q;
    logic [1:0]           size_q;
    logic [AW-1:0]        pc_q, base_q;
    logic [EW-1:0]        w1_q;
    amode_t               am;
    logic [REG_IDX_W-1:0] base_idx;
    logic                 two_words, is_index, pc_based;
    logic [AW-1:0]        inc_val, dec_val, idx_ea, pc_step, ext_sx;
    loc_t                 loc_q;

    logic                 fin, f_wb, cap_base, cap_w1, pc_adv;
    loc_t                 f_loc;
    logic [REG_IDX_W-1:0] f_reg;
    logic [AW-1:0]        f_addr, f_imm, f_wbv, f_pc;

    opa_mode_map u_map (
        .mode(mode_q), .regf(regf_q), .size(size_q), .am(am),
        .base_idx(base_idx), .two_words(two_words),
        .is_index(is_index), .pc_based(pc_based)
    );

    opa_size_step #(.AW(AW)) u_step (
        .size(size_q), .base(rf_data), .inc_val(inc_val), .dec_val(dec_val)
    );

    opa_index_add #(.AW(AW), .EW(EW)) u_idx (
        .base(base_q), .ext_word(w1_q), .idx_val(rf_data), .ea(idx_ea)
    );

    assign pc_step  = pc_q + WORD_BYTES;
    assign ext_sx   = {{(AW-EW){ext_data[EW-1]}}, ext_data};
    assign ext_addr = pc_q;
    assign rf_idx   = (st == ST_INDEX) ? w1_q[EW-1 -: REG_IDX_W] : base_idx;
    assign loc      = loc_q;

    // Next state, fetch request and the result to commit on finish.
    always_comb begin
        nxt      = st;
        fin      = 1'b0;
        f_loc    = LOC_MEM;
        f_reg    = '0;
        f_addr   = '0;
        f_imm    = '0;
        f_wb     = 1'b0;
        f_wbv    = '0;
        f_pc     = pc_q;
        cap_base = 1'b0;
        cap_w1   = 1'b0;
        pc_adv   = 1'b0;
        ext_req  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (start) nxt = ST_BASE;
            end
            ST_BASE: begin
                case (am)
                    AM_DREG, AM_AREG: begin
                        fin   = 1'b1;
                        f_loc = LOC_REG;
                        f_reg = base_idx;
                    end
                    AM_IND: begin
                        fin    = 1'b1;
                        f_addr = rf_data;
                    end
                    AM_POST: begin
                        fin    = 1'b1;
                        f_addr = rf_data;
                        f_wb   = 1'b1;
                        f_wbv  = inc_val;
                    end
                    AM_PRE: begin
                        fin    = 1'b1;
                        f_addr = dec_val;
                        f_wb   = 1'b1;
                        f_wbv  = dec_val;
                    end
                    AM_BAD: begin
                        fin   = 1'b1;
                        f_loc = LOC_BAD;
                    end
                    default: begin
                        cap_base = 1'b1;
                        nxt      = ST_EXT1;
                    end
                endcase
            end
            ST_EXT1: begin
                ext_req = 1'b1;
                if (ext_ack) begin
                    cap_w1 = 1'b1;
                    pc_adv = 1'b1;
                    f_pc   = pc_step;
                    if (two_words) begin
                        nxt = ST_EXT2;
                    end else if (is_index) begin
                        nxt = ST_INDEX;
                    end else begin
                        fin = 1'b1;
                        case (am)
                            AM_ABSW: f_addr = ext_sx;
                            AM_IMM: begin
                                f_loc = LOC_IMM;
                                f_imm = (size_q == 2'd0) ? AW'(ext_data[7:0]) : AW'(ext_data);
                            end
                            default: f_addr = base_q + ext_sx;
                        endcase
                    end
                end
            end
            ST_EXT2: begin
                ext_req = 1'b1;
                if (ext_ack) begin
                    pc_adv = 1'b1;
                    f_pc   = pc_step;
                    fin    = 1'b1;
                    if (am == AM_IMM) begin
                        f_loc = LOC_IMM;
                        f_imm = AW'({w1_q, ext_data});
                    end else begin
                        f_addr = AW'({w1_q, ext_data});
                    end
                end
            end
            ST_INDEX: begin
                fin    = 1'b1;
                f_addr = idx_ea;
            end
            default: nxt = ST_IDLE;
        endcase
        if (fin) nxt = ST_IDLE;
    end

    // Sequencer state, captured fields and held results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            done    <= 1'b0;
            wb_en   <= 1'b0;
            mode_q  <= '0;
            regf_q  <= '0;
            size_q  <= '0;
            pc_q    <= '0;
            base_q  <= '0;
            w1_q    <= '0;
            loc_q   <= LOC_REG;
            reg_idx <= '0;
            addr    <= '0;
            imm     <= '0;
            wb_idx  <= '0;
            wb_val  <= '0;
            pc_next <= '0;
        end else begin
            st    <= nxt;
            done  <= fin;
            wb_en <= fin & f_wb;
            if (st == ST_IDLE && start) begin
                mode_q <= mode_i;
                regf_q <= regf_i;
                size_q <= size_i;
                pc_q   <= pc_i;
            end
            if (pc_adv) pc_q <= pc_step;
            if (cap_base) base_q <= pc_based ? pc_q : rf_data;
            if (cap_w1) w1_q <= ext_data;
            if (fin) begin
                loc_q   <= f_loc;
                reg_idx <= f_reg;
                addr    <= f_addr;
                imm     <= f_imm;
                wb_idx  <= base_idx;
                wb_val  <= f_wbv;
                pc_next <= f_pc;
            end
        end
    end
endmodule

// File: rtl/opa_checker.sv
// Protocol and result-shape properties for opaddr_unit, bound below.
module opa_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          done,
    input logic [1:0]    loc,
    input logic          wb_en,
    input logic [3:0]    wb_idx,
    input logic          ext_req,
    input logic          ext_ack,
    input logic [AW-1:0] ext_addr
);
    // R12: an unanswered request holds its address
    a_r12_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_ack |=> ext_req && $stable(ext_addr));

    // R12: an accepted word moves the fetch address by one word
    a_r12_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && ext_ack |=> !ext_req || (ext_addr == $past(ext_addr) + AW'(2)));

    // R13: done is a single-cycle pulse
    a_r13_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R13: no fetch outstanding while reporting
    a_r13_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ext_req);

    // R4: write-back only with a memory result on an address register
    a_r4_wb_shape: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done && (loc == 2'd1) && wb_idx[3]);

    // R11: illegal specifier never writes back
    a_r11_bad_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        done && (loc == 2'd3) |-> !wb_en);
endmodule

bind opaddr_unit opa_checker #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .loc(loc), .wb_en(wb_en),
    .wb_idx(wb_idx), .ext_req(ext_req), .ext_ack(ext_ack), .ext_addr(ext_addr)
);

// File: tb/sim_opaddr_unit.sv
`timescale 1ns/1ps
module sim_opaddr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode_i = '0, regf_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] pc_i = '0;
    logic        ext_req, ext_ack;
    logic [31:0] ext_addr;
    logic [15:0] ext_data;
    logic [3:0]  rf_idx;
    logic [31:0] rf_data;
    logic        done, wb_en;
    logic [1:0]  loc;
    logic [3:0]  reg_idx, wb_idx;
    logic [31:0] addr, imm, wb_val, pc_next;

    logic [31:0] regs [0:15];
    logic [15:0] xmem [0:3];
    logic [31:0] xbase = '0;
    logic [31:0] xoff;
    logic        stall = 1'b0;
    logic        stall_mode = 1'b0;
    int          nfetch = 0;
    int          n_tests = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    assign xoff     = ext_addr - xbase;
    assign ext_data = xmem[xoff[2:1]];
    assign ext_ack  = ext_req & ~stall;
    assign rf_data  = regs[rf_idx];

    opaddr_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_i(mode_i), .regf_i(regf_i),
        .size_i(size_i), .pc_i(pc_i), .ext_req(ext_req), .ext_addr(ext_addr),
        .ext_ack(ext_ack), .ext_data(ext_data), .rf_idx(rf_idx), .rf_data(rf_data),
        .done(done), .loc(loc), .reg_idx(reg_idx), .addr(addr), .imm(imm),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_val(wb_val), .pc_next(pc_next)
    );

    // Alternating wait states when enabled.
    always @(negedge clk) stall = stall_mode ? ~stall : 1'b0;

    // Count accepted extension words.
    always @(posedge clk) if (ext_req && ext_ack) nfetch = nfetch + 1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                         input logic [31:0] pc);
        @(negedge clk);
        nfetch = 0;
        xbase  = pc;
        mode_i = m; regf_i = r; size_i = s; pc_i = pc;
        start  = 1'b1;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int cyc = 0;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        chk({tag, " done seen"}, {31'd0, done}, 32'd1);
    endtask

    task automatic run(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                       input logic [31:0] pc, input string tag);
        issue(m, r, s, pc);
        wait_done(tag);
    endtask

    task automatic t_reset();
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 wb_en", {31'd0, wb_en}, 32'd0);
        chk("R1 ext_req", {31'd0, ext_req}, 32'd0);
    endtask

    task automatic t_direct();
        run(3'd0, 3'd5, 2'd1, 32'h100, "R2");
        chk("R2 data loc", {30'd0, loc}, 32'd0);
        chk("R2 data idx", {28'd0, reg_idx}, 32'd5);
        chk("R2 no fetch", nfetch, 32'd0);
        run(3'd1, 3'd3, 2'd2, 32'h100, "R2");
        chk("R2 addr-reg idx", {28'd0, reg_idx}, 32'd11);
    endtask

    task automatic t_indirect();
        run(3'd2, 3'd2, 2'd1, 32'h100, "R3");
        chk("R3 loc", {30'd0, loc}, 32'd1);
        chk("R3 addr", addr, 32'h0000_4000);
        chk("R3 no wb", {31'd0, wb_en}, 32'd0);
    endtask

    task automatic t_post();
        run(3'd3, 3'd3, 2'd2, 32'h100, "R4");
        chk("R4 long addr", addr, 32'h100);
        chk("R4 wb_en", {31'd0, wb_en}, 32'd1);
        chk("R4 wb_idx", {28'd0, wb_idx}, 32'd11);
        chk("R4 long wb", wb_val, 32'h104);
        run(3'd3, 3'd3, 2'd1, 32'h100, "R4");
        chk("R4 word wb", wb_val, 32'h102);
        run(3'd3, 3'd3, 2'd0, 32'h100, "R4");
        chk("R4 byte wb", wb_val, 32'h102);
    endtask

    task automatic t_pre();
        run(3'd4, 3'd4, 2'd2, 32'h100, "R5");
        chk("R5 long addr", addr, 32'h1FC);
        chk("R5 long wb", wb_val, 32'h1FC);
        run(3'd4, 3'd4, 2'd0, 32'h100, "R5");
        chk("R5 byte addr", addr, 32'h1FE);
    endtask

    task automatic t_disp();
        xmem[0] = 16'hFFF0;
        run(3'd5, 3'd1, 2'd1, 32'h1000, "R6");
        chk("R6 addr", addr, 32'h7FF0);
        chk("R6 pc_next", pc_next, 32'h1002);
        chk("R6 fetches", nfetch, 32'd1);
    endtask

    task automatic t_index();
        xmem[0] = 16'h2080;
        run(3'd6, 3'd5, 2'd1, 32'h1000, "R7");
        chk("R7 half index", addr, 32'h0000_2F7E);
        xmem[0] = 16'h2880;
        run(3'd6, 3'd5, 2'd1, 32'h1000, "R7");
        chk("R7 full index", addr, 32'h0002_2F7E);
        xmem[0] = 16'hA804;
        run(3'd6, 3'd5, 2'd1, 32'h1000, "R7");
        chk("R7 addr-reg index", addr, 32'h0000_7004);
    endtask

    task automatic t_abs();
        xmem[0] = 16'h8000;
        run(3'd7, 3'd0, 2'd1, 32'h1000, "R8");
        chk("R8 short", addr, 32'hFFFF_8000);
        chk("R8 short pc", pc_next, 32'h1002);
        xmem[0] = 16'h1234; xmem[1] = 16'h5678;
        run(3'd7, 3'd1, 2'd1, 32'h1000, "R8");
        chk("R8 long", addr, 32'h1234_5678);
        chk("R8 long pc", pc_next, 32'h1004);
    endtask

    task automatic t_pcrel();
        xmem[0] = 16'h0010;
        run(3'd7, 3'd2, 2'd1, 32'h2000, "R9");
        chk("R9 pc disp", addr, 32'h2010);
        xmem[0] = 16'h2006;
        run(3'd7, 3'd3, 2'd1, 32'h2000, "R9");
        chk("R9 pc index", addr, 32'h2004);
    endtask

    task automatic t_imm();
        xmem[0] = 16'h12AB;
        run(3'd7, 3'd4, 2'd0, 32'h1000, "R10");
        chk("R10 loc", {30'd0, loc}, 32'd2);
        chk("R10 byte", imm, 32'h0000_00AB);
        run(3'd7, 3'd4, 2'd1, 32'h1000, "R10");
        chk("R10 word", imm, 32'h0000_12AB);
        xmem[0] = 16'hDEAD; xmem[1] = 16'hBEEF;
        run(3'd7, 3'd4, 2'd2, 32'h1000, "R10");
        chk("R10 long", imm, 32'hDEAD_BEEF);
        chk("R10 long pc", pc_next, 32'h1004);
    endtask

    task automatic t_bad();
        run(3'd7, 3'd5, 2'd1, 32'h1000, "R11");
        chk("R11 loc", {30'd0, loc}, 32'd3);
        chk("R11 no fetch", nfetch, 32'd0);
        chk("R11 no wb", {31'd0, wb_en}, 32'd0);
        chk("R11 pc", pc_next, 32'h1000);
    endtask

    task automatic t_stall_busy();
        logic [31:0] held;
        stall_mode = 1'b1;
        xmem[0] = 16'hCAFE; xmem[1] = 16'hF00D;
        issue(3'd7, 3'd1, 2'd2, 32'h3000);
        mode_i = 3'd0; regf_i = 3'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R13");
        chk("R12 stalled result", addr, 32'hCAFE_F00D);
        chk("R12 stalled fetches", nfetch, 32'd2);
        chk("R12 stalled pc", pc_next, 32'h3004);
        chk("R13 busy start ignored", {30'd0, loc}, 32'd1);
        held = addr;
        stall_mode = 1'b0;
        @(negedge clk);
        chk("R13 pulse width", {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        chk("R13 no late done", {31'd0, done}, 32'd0);
        chk("R13 result held", addr, held);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = 32'h10 + i * 32'h111;
        regs[2]  = 32'h0001_FFFE;
        regs[9]  = 32'h0000_8000;
        regs[10] = 32'h0000_4000;
        regs[11] = 32'h0000_0100;
        regs[12] = 32'h0000_0200;
        regs[13] = 32'h0000_3000;
        for (int i = 0; i < 4; i++) xmem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_direct();
        t_indirect();
        t_post();
        t_pre();
        t_disp();
        t_index();
        t_abs();
        t_pcrel();
        t_imm();
        t_bad();
        t_stall_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R13 watchdog actual=hung expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule